// File: doc/BRIEF.md
# Alternating Read/Write Transaction Arbiter

This block sits between the command side of a memory-mapped to shared-bus bridge and the sequencer that drives the shared bus. In every free cycle it decides whether the next bus transaction serves a waiting read or a waiting write. A read is waiting whenever a read command is present. A write waits only once its address command is held and its first data beat has also been accepted.

When both directions wait at once, the block favours the direction opposite to the one it granted last. So neither reads nor writes can keep the bus to themselves. Only one transaction is outstanding at a time. After a grant, the block waits until the sequencer reports the end of the bus transfers. It also waits until the requesting side has accepted the final response of that granted direction. It is free again in the very cycle both have happened, so single-beat traffic with always-ready response channels can start a new transaction on every clock.

The decision is registered. A one-hot grant and a one-cycle start pulse appear on the clock edge that takes the decision.

Top module: `rw_turn_arbiter`

## Requirements
- R1: A write counts as waiting only while both `wr_cmd_i` and `wr_beat_i` are high; either one alone never produces a write grant.
- R2: When the arbiter is free and only one direction is waiting, that direction is granted on the next clock edge, whatever was granted before.
- R3: When both directions wait in a free cycle and the last grant was a read, the write is granted.
- R4: When both directions wait in a free cycle and the last grant was a write, the read is granted; after reset the history reads as "write", so the first tie goes to the read.
- R5: `grant_o` is one-hot or zero (bit 0 = read, bit 1 = write). It holds its value from the start pulse until the transaction is released, and it is zero while nothing is outstanding.
- R6: `start_o` is high for exactly the cycle in which a new grant value first appears, and it is never high with `grant_o` zero.
- R7: After a grant, no new start happens until `seq_done_i` has been seen and, in the same or a later cycle, the response accept of the granted direction (`rd_rsp_acc_i` for a read, `wr_rsp_acc_i` for a write); an accept pulse for the other direction has no effect.
- R8: If `seq_done_i` and the matching response accept arrive in the same cycle while a request waits, the next grant starts on that same clock edge, so single-beat transactions can start on consecutive cycles.
- R9: While reset is applied and on its release, `grant_o` and `start_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_cmd_i | input | 1 | A read command is present |
| wr_cmd_i | input | 1 | A write address command is held |
| wr_beat_i | input | 1 | The first data beat of the held write has been accepted |
| seq_done_i | input | 1 | Sequencer pulse: bus transfers of the granted transaction are finished |
| rd_rsp_acc_i | input | 1 | Final read response beat accepted by the requester |
| wr_rsp_acc_i | input | 1 | Write response accepted by the requester |
| grant_o | output | 2 | One-hot grant, bit 0 read, bit 1 write |
| start_o | output | 1 | One-cycle pulse that launches the granted transaction |

## Verification
The release of one transaction and the decision for the next can fall into the same cycle. Sequencer completion, response acceptance and a fresh tie between read and write can all arrive together. The bench provokes this by raising `seq_done_i` and the matching accept together while both directions wait. It expects the start of the opposite direction on that same edge, and a run of back-to-back single reads with starts on consecutive cycles. A scoreboard queue holds the expected grant for every start. It flags any start that was not predicted, any wrong direction, and any prediction left unmatched. This includes accepts of the wrong direction, which must not free the arbiter.

// File: rtl/rw_turn_pkg.sv
package rw_turn_pkg;
  localparam int unsigned DIR_N  = 2;
  localparam int unsigned RD_IDX = 0;
  localparam int unsigned WR_IDX = 1;
  localparam int unsigned SYNC_STAGES = 2;

  typedef logic [DIR_N-1:0] dir_vec_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_RSP  = 2'd2
  } turn_st_e;
endpackage

// File: rtl/rw_turn_rst_sync.sv
module rw_turn_rst_sync #(
  parameter int unsigned STAGES = rw_turn_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rw_turn_pick.sv
module rw_turn_pick
  import rw_turn_pkg::*;
(
  input  logic     rd_req_i,
  input  logic     wr_req_i,
  input  logic     last_wr_i,
  output dir_vec_t pick_o
);
  always_comb begin
    pick_o = '0;
    if (rd_req_i && wr_req_i) begin
      if (last_wr_i) pick_o[RD_IDX] = 1'b1;
      else           pick_o[WR_IDX] = 1'b1;
    end else if (rd_req_i) begin
      pick_o[RD_IDX] = 1'b1;
    end else if (wr_req_i) begin
      pick_o[WR_IDX] = 1'b1;
    end
  end
endmodule

// File: rtl/rw_turn_ctrl.sv
module rw_turn_ctrl
  import rw_turn_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dir_vec_t pick_i,
  input  logic     seq_done_i,
  input  logic     rd_rsp_acc_i,
  input  logic     wr_rsp_acc_i,
  output logic     last_wr_o,
  output dir_vec_t grant_o,
  output logic     start_o
);
  turn_st_e st_q, st_d;
  dir_vec_t grant_q, grant_d;
  logic     start_q, start_d;
  logic     last_wr_q, last_wr_d;
  logic     acc_mine, free_now;

  always_comb begin
    acc_mine = (grant_q[RD_IDX] && rd_rsp_acc_i) || (grant_q[WR_IDX] && wr_rsp_acc_i);
    free_now = (st_q == ST_IDLE) ||
               (st_q == ST_RSP && acc_mine) ||
               (st_q == ST_RUN && seq_done_i && acc_mine);
  end

  always_comb begin
    st_d      = st_q;
    grant_d   = grant_q;
    start_d   = 1'b0;
    last_wr_d = last_wr_q;
    if (free_now) begin
      if (|pick_i) begin
        st_d      = ST_RUN;
        grant_d   = pick_i;
        start_d   = 1'b1;
        last_wr_d = pick_i[WR_IDX];
      end else begin
        st_d    = ST_IDLE;
        grant_d = '0;
      end
    end else if (st_q == ST_RUN && seq_done_i) begin
      st_d = ST_RSP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      grant_q   <= '0;
      start_q   <= 1'b0;
      last_wr_q <= 1'b1;
    end else begin
      st_q      <= st_d;
      grant_q   <= grant_d;
      start_q   <= start_d;
      last_wr_q <= last_wr_d;
    end
  end

  assign grant_o   = grant_q;
  assign start_o   = start_q;
  assign last_wr_o = last_wr_q;

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R6
  start_has_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (grant_o != '0));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !seq_done_i) |=> (grant_o == $past(grant_o)));

  // R7
  rsp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RSP && !rd_rsp_acc_i && !wr_rsp_acc_i) |=> !start_o);
endmodule

// File: rtl/rw_turn_arbiter.sv
module rw_turn_arbiter
  import rw_turn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_cmd_i,
  input  logic       wr_cmd_i,
  input  logic       wr_beat_i,
  input  logic       seq_done_i,
  input  logic       rd_rsp_acc_i,
  input  logic       wr_rsp_acc_i,
  output logic [1:0] grant_o,
  output logic       start_o
);
  logic     rst_sync_n;
  logic     wr_req;
  logic     last_wr;
  dir_vec_t pick;

  assign wr_req = wr_cmd_i && wr_beat_i;

  rw_turn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rw_turn_pick u_pick (
    .rd_req_i  (rd_cmd_i),
    .wr_req_i  (wr_req),
    .last_wr_i (last_wr),
    .pick_o    (pick)
  );

  rw_turn_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .pick_i       (pick),
    .seq_done_i   (seq_done_i),
    .rd_rsp_acc_i (rd_rsp_acc_i),
    .wr_rsp_acc_i (wr_rsp_acc_i),
    .last_wr_o    (last_wr),
    .grant_o      (grant_o),
    .start_o      (start_o)
  );

  // R1
  wr_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_o && grant_o[WR_IDX]) |-> $past(wr_cmd_i && wr_beat_i));

  // R2
  rd_only_grant_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_o && grant_o[RD_IDX]) |-> $past(rd_cmd_i));
endmodule

// File: tb/tb_rw_turn_arbiter.sv
module tb_rw_turn_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_cmd, wr_cmd, wr_beat, seq_done, rd_acc, wr_acc;
  logic [1:0] grant;
  logic       start;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          live   = 1'b0;
  bit          done   = 1'b0;
  logic [1:0]  exp_q[$];

  localparam logic [1:0] G_RD = 2'b01;
  localparam logic [1:0] G_WR = 2'b10;

  always #5 clk = ~clk;

  rw_turn_arbiter dut (
    .clk(clk), .rst_n(rst_n), .rd_cmd_i(rd_cmd), .wr_cmd_i(wr_cmd),
    .wr_beat_i(wr_beat), .seq_done_i(seq_done), .rd_rsp_acc_i(rd_acc),
    .wr_rsp_acc_i(wr_acc), .grant_o(grant), .start_o(start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_start(input logic [1:0] g);
    exp_q.push_back(g);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (live && start) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected start", int'(grant), 0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk(grant == e, "R2/R3/R4 grant at start", int'(grant), int'(e));
      end
    end
  end

  initial begin
    #(20000 * 10);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_cmd = 0; wr_cmd = 0; wr_beat = 0;
    seq_done = 0; rd_acc = 0; wr_acc = 0;
    tick(); tick();
    chk(grant == 2'b00, "R9 grant in reset", int'(grant), 0);
    chk(start == 1'b0,  "R9 start in reset", int'(start), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(grant == 2'b00 && start == 1'b0, "R9 after release", int'({grant, start}), 0);
    live = 1'b1;

    // R4: first tie after reset goes to read
    rd_cmd = 1; wr_cmd = 1; wr_beat = 1;
    expect_start(G_RD);
    tick();
    chk(start == 1'b1, "R4 first tie start", int'(start), 1);
    rd_cmd = 0;
    tick();
    chk(grant == G_RD && start == 1'b0, "R5 R6 grant held, pulse one cycle", int'({grant, start}), int'({G_RD, 1'b0}));
    // R8: done + accept together with a write waiting
    seq_done = 1; rd_acc = 1;
    expect_start(G_WR);
    tick();
    chk(start == 1'b1 && grant == G_WR, "R8 same-edge restart", int'(grant), int'(G_WR));
    seq_done = 0; rd_acc = 0; wr_cmd = 0; wr_beat = 0;

    // R7: split completion, wrong-direction accept ignored
    tick();
    seq_done = 1; tick(); seq_done = 0;
    rd_cmd = 1;
    tick();
    chk(start == 1'b0 && grant == G_WR, "R7 wait for response", int'(grant), int'(G_WR));
    rd_acc = 1; tick(); rd_acc = 0;
    chk(start == 1'b0 && grant == G_WR, "R7 other accept ignored", int'(grant), int'(G_WR));
    tick();
    wr_acc = 1;
    expect_start(G_RD);
    tick();
    chk(start == 1'b1 && grant == G_RD, "R7 released by own accept", int'(grant), int'(G_RD));
    wr_acc = 0;

    // R3: last was read, tie goes to write
    wr_cmd = 1; wr_beat = 1;
    tick();
    seq_done = 1; rd_acc = 1;
    expect_start(G_WR);
    tick();
    chk(grant == G_WR, "R3 tie after read", int'(grant), int'(G_WR));
    seq_done = 0; rd_acc = 0; wr_cmd = 0; wr_beat = 0;
    tick();
    seq_done = 1; wr_acc = 1;
    expect_start(G_RD);
    tick();
    chk(grant == G_RD, "R2 read alone after write", int'(grant), int'(G_RD));
    rd_cmd = 0; wr_acc = 0;
    rd_acc = 1;
    tick();
    seq_done = 0; rd_acc = 0;
    chk(grant == 2'b00 && start == 1'b0, "R5 idle grant zero", int'(grant), 0);

    // R1: write needs both address and first beat
    wr_cmd = 1; repeat (3) tick();
    chk(grant == 2'b00, "R1 address alone", int'(grant), 0);
    wr_cmd = 0; wr_beat = 1; repeat (3) tick();
    chk(grant == 2'b00, "R1 beat alone", int'(grant), 0);
    wr_cmd = 1;
    expect_start(G_WR);
    tick();
    chk(start == 1'b1 && grant == G_WR, "R1 both present", int'(grant), int'(G_WR));
    wr_cmd = 0; wr_beat = 0;
    seq_done = 1; wr_acc = 1; tick();
    seq_done = 0; wr_acc = 0;
    chk(grant == 2'b00, "R5 idle after write", int'(grant), 0);

    // R8: gapless single reads
    rd_cmd = 1;
    repeat (4) expect_start(G_RD);
    tick();
    chk(start == 1'b1, "R8 burst start 1", int'(start), 1);
    seq_done = 1; rd_acc = 1;
    for (int i = 2; i <= 4; i++) begin
      tick();
      chk(start == 1'b1, "R8 consecutive start", int'(start), 1);
    end
    rd_cmd = 0;
    tick();
    seq_done = 0; rd_acc = 0;
    chk(grant == 2'b00 && start == 1'b0, "R8 idle after burst", int'(grant), 0);

    tick();
    chk(exp_q.size() == 0, "R6 all predicted starts seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule